// File: doc/BRIEF.md
# Six-step brushless motor commutation gate controller

This block turns a three-bit rotor position into the on/off pattern of the six gates of a three-phase bridge: one high-side and one low-side gate for each of the phases U, V and W. The position comes from one of two places. It can come from three Hall-sensor inputs, which are synchronised and watched for edges. It can also come from three phase bits that software writes. A source-select input chooses between them. Switching the source takes effect on the next clock, so the bridge can be handed between sensored start-up and software-driven stepping while the motor turns.

Each side of the bridge has two settings of its own. The first is a chop enable. With chopping on, a gate that is switched on follows an externally generated PWM signal for that side. With chopping off, the gate holds a steady active level. The second is an active-level select, which sets the polarity of the gate. An off gate always sits at the inverse of its side's active level. The PWM carrier and the dead time are generated outside the block, and each side has its own PWM input so that the external dead time is kept.

Top module: `bldc_commutator`

## Requirements
- R1: While reset is asserted and until the first position is loaded, the latched position code is 000, so every gate sits at the inverse of its side's active level.
- R2: With fbSel=0, a change on hallIn appears on the gates on the third rising clock after the input changes: two synchroniser stages, then one load register. Before that the gates keep the previous pattern.
- R3: With fbSel=1, a change on swPhase appears on the gates after the first rising clock that follows the change.
- R4: Position code bit 2 is U, bit 1 is V and bit 0 is W. Gate index 0 is U, 1 is V and 2 is W. The on phases (high, low) for each code are: 101 gives (U, V), 100 gives (U, W), 110 gives (V, W), 010 gives (V, U), 011 gives (W, U), and 001 gives (W, V).
- R5: Codes 000 and 111 switch all six gates off.
- R6: With chopEnHi=1, an on high-side gate is active while pwmHi=1 and inactive while pwmHi=0. With chopEnHi=0 it is steadily active and pwmHi has no effect.
- R7: With chopEnLo=1, an on low-side gate is active while pwmLo=1 and inactive while pwmLo=0. With chopEnLo=0 it is steadily active and pwmLo has no effect.
- R8: actLvlHi and actLvlLo set the active level of their side (1 means active high, 0 means active low). Off gates take the inverse level, whatever the chop settings are.
- R9: For a valid code with chopping off, exactly one high-side gate and exactly one low-side gate are active, and they are on different phases. No phase ever has both of its gates active.
- R10: Changing fbSel loads the code of the newly selected source on the next rising clock.
- R11: With fbSel=1, changes on hallIn leave the gates unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hallIn | input | 3 | Hall-sensor position inputs {U,V,W}, asynchronous |
| fbSel | input | 1 | Position source: 0 selects Hall inputs, 1 selects software bits |
| swPhase | input | 3 | Software-written position bits {U,V,W} |
| chopEnHi | input | 1 | High-side chop enable |
| chopEnLo | input | 1 | Low-side chop enable |
| actLvlHi | input | 1 | High-side active level |
| actLvlLo | input | 1 | Low-side active level |
| pwmHi | input | 1 | External chopping signal for the high side |
| pwmLo | input | 1 | External chopping signal for the low side |
| gateHi | output | 3 | High-side gate outputs, index 0 is U |
| gateLo | output | 3 | Low-side gate outputs, index 0 is U |

## Verification
The six valid Hall codes are stepped in forward rotation order and then in reverse order. At each step the bench checks that nothing changes on the second clock and that the new pattern appears on the third, which separates a correct synchroniser depth from a short or missing stage. At every position, all 64 combinations of the two chop enables, the two active levels and the two PWM inputs are applied. This separates the high-side controls from the low-side ones and shows whether polarity is applied to off gates as well. Software mode walks all eight codes, including 000 and 111. Directed cases then toggle Hall inputs in software mode and flip the source select in both directions while the motor runs.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int PHASES   = 3;
  localparam int CODE_W   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [CODE_W-1:0] code;
  } cmdT;
endpackage

// File: rtl/bldc_ctrl.sv
module bldc_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [bldc_pkg::CODE_W-1:0]  hallIn,
  input  logic                         fbSel,
  input  logic [bldc_pkg::CODE_W-1:0]  swPhase,
  output bldc_pkg::cmdT                cmd
);
  import bldc_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][CODE_W-1:0] syncQ;
  logic [CODE_W-1:0] hallPrev;
  logic [CODE_W-1:0] swPrev;
  logic              fbPrev;
  logic              hallEdge;
  logic              swEdge;
  logic              srcSwap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= hallIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hallPrev <= '0;
      swPrev   <= '0;
      fbPrev   <= 1'b0;
    end else begin
      hallPrev <= syncQ[LAST];
      swPrev   <= swPhase;
      fbPrev   <= fbSel;
    end
  end

  assign hallEdge = syncQ[LAST] != hallPrev;
  assign swEdge   = swPhase != swPrev;
  assign srcSwap  = fbSel != fbPrev;

  always_comb begin
    cmd.code = fbSel ? swPhase : syncQ[LAST];
    cmd.load = srcSwap || (fbSel ? swEdge : hallEdge);
  end
endmodule

// File: rtl/bldc_dp.sv
module bldc_dp (
  input  logic                         clk,
  input  logic                         rstN,
  input  bldc_pkg::cmdT                cmd,
  input  logic                         chopEnHi,
  input  logic                         chopEnLo,
  input  logic                         actLvlHi,
  input  logic                         actLvlLo,
  input  logic                         pwmHi,
  input  logic                         pwmLo,
  output logic [bldc_pkg::PHASES-1:0]  gateHi,
  output logic [bldc_pkg::PHASES-1:0]  gateLo
);
  import bldc_pkg::*;

  logic [CODE_W-1:0] stateCode;
  logic [PHASES-1:0] onHi;
  logic [PHASES-1:0] onLo;
  logic              passHi;
  logic              passLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         stateCode <= '0;
    else if (cmd.load) stateCode <= cmd.code;
  end

  // six-step table, code {U,V,W}, masks index 0 = U
  always_comb begin
    unique case (stateCode)
      3'b101:  begin onHi = 3'b001; onLo = 3'b010; end
      3'b100:  begin onHi = 3'b001; onLo = 3'b100; end
      3'b110:  begin onHi = 3'b010; onLo = 3'b100; end
      3'b010:  begin onHi = 3'b010; onLo = 3'b001; end
      3'b011:  begin onHi = 3'b100; onLo = 3'b001; end
      3'b001:  begin onHi = 3'b100; onLo = 3'b010; end
      default: begin onHi = 3'b000; onLo = 3'b000; end
    endcase
  end

  assign passHi = !chopEnHi || pwmHi;
  assign passLo = !chopEnLo || pwmLo;

  for (genvar p = 0; p < PHASES; p++) begin : gPhase
    assign gateHi[p] = (onHi[p] && passHi) ? actLvlHi : ~actLvlHi;
    assign gateLo[p] = (onLo[p] && passLo) ? actLvlLo : ~actLvlLo;
  end

  // assertions
  logic [PHASES-1:0] activeHi;
  logic [PHASES-1:0] activeLo;
  logic              codeValid;
  assign activeHi  = gateHi ^ {PHASES{~actLvlHi}};
  assign activeLo  = gateLo ^ {PHASES{~actLvlLo}};
  assign codeValid = (stateCode != 3'b000) && (stateCode != 3'b111);

  assert_state_needs_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != $past(stateCode)) |-> $past(cmd.load));

  assert_invalid_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |-> (activeHi == '0 && activeLo == '0));

  assert_one_hi_R9: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !chopEnHi) |-> $countones(activeHi) == 1);

  assert_one_lo_R9: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !chopEnLo) |-> $countones(activeLo) == 1);

  assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (activeHi & activeLo) == '0);
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hallIn,
  input  logic       fbSel,
  input  logic [2:0] swPhase,
  input  logic       chopEnHi,
  input  logic       chopEnLo,
  input  logic       actLvlHi,
  input  logic       actLvlLo,
  input  logic       pwmHi,
  input  logic       pwmLo,
  output logic [2:0] gateHi,
  output logic [2:0] gateLo
);
  import bldc_pkg::*;

  cmdT cmd;

  bldc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hallIn  (hallIn),
    .fbSel   (fbSel),
    .swPhase (swPhase),
    .cmd     (cmd)
  );

  bldc_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .chopEnHi (chopEnHi),
    .chopEnLo (chopEnLo),
    .actLvlHi (actLvlHi),
    .actLvlLo (actLvlLo),
    .pwmHi    (pwmHi),
    .pwmLo    (pwmLo),
    .gateHi   (gateHi),
    .gateLo   (gateLo)
  );
endmodule

// File: tb/sim_bldc_commutator.sv
module sim_bldc_commutator;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hallIn = 3'b000;
  logic       fbSel = 1'b0;
  logic [2:0] swPhase = 3'b000;
  logic       chopEnHi = 1'b0, chopEnLo = 1'b0;
  logic       actLvlHi = 1'b1, actLvlLo = 1'b1;
  logic       pwmHi = 1'b0, pwmLo = 1'b0;
  logic [2:0] gateHi, gateLo;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bldc_commutator u0 (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .fbSel(fbSel), .swPhase(swPhase),
    .chopEnHi(chopEnHi), .chopEnLo(chopEnLo), .actLvlHi(actLvlHi), .actLvlLo(actLvlLo),
    .pwmHi(pwmHi), .pwmLo(pwmLo), .gateHi(gateHi), .gateLo(gateLo)
  );

  // {code{U,V,W}, hiMask, loMask}; first six in forward rotation order (R4)
  localparam logic [8:0] VEC [8] = '{
    {3'b101, 3'b001, 3'b010},
    {3'b100, 3'b001, 3'b100},
    {3'b110, 3'b010, 3'b100},
    {3'b010, 3'b010, 3'b001},
    {3'b011, 3'b100, 3'b001},
    {3'b001, 3'b100, 3'b010},
    {3'b000, 3'b000, 3'b000},
    {3'b111, 3'b000, 3'b000}
  };

  function automatic logic [2:0] expGate(logic [2:0] mask, logic chop, logic pwm, logic act);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = (mask[i] && (!chop || pwm)) ? act : ~act;
    return r;
  endfunction

  task automatic chk(string tag, logic [2:0] expHi, logic [2:0] expLo);
    checks++;
    if (gateHi !== expHi || gateLo !== expLo) begin
      failures++;
      $display("FAIL %s: gateHi=%b gateLo=%b expected gateHi=%b gateLo=%b",
               tag, gateHi, gateLo, expHi, expLo);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steadyCfg();
    chopEnHi = 0; chopEnLo = 0; actLvlHi = 1; actLvlLo = 1; pwmHi = 0; pwmLo = 0;
  endtask

  // all 64 settings of chop, level and pwm for one pattern (R6 R7 R8)
  task automatic sweepCfg(logic [2:0] hiM, logic [2:0] loM, string tag);
    for (int c = 0; c < 64; c++) begin
      chopEnHi = c[0]; chopEnLo = c[1]; actLvlHi = c[2]; actLvlLo = c[3];
      pwmHi = c[4]; pwmLo = c[5];
      #1;
      chk(tag, expGate(hiM, chopEnHi, pwmHi, actLvlHi), expGate(loM, chopEnLo, pwmLo, actLvlLo));
      @(negedge clk);
    end
    steadyCfg();
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0] prevHi, prevLo;
    int idx;
    // R1: reset state, both polarities
    #1;
    chk("R1 reset active-high", 3'b000, 3'b000);
    actLvlHi = 0; actLvlLo = 0; #1;
    chk("R1 reset active-low R8", 3'b111, 3'b111);
    actLvlHi = 1; actLvlLo = 1;
    tick(3);
    rstN = 1'b1;
    tick(2);
    chk("R1 after reset", 3'b000, 3'b000);

    // R2 R4: hall walk forward then reverse
    prevHi = 3'b000; prevLo = 3'b000;
    for (int dir = 0; dir < 2; dir++) begin
      for (int s = 0; s < 6; s++) begin
        idx = (dir == 0) ? s : 5 - s;
        hallIn = VEC[idx][8:6];
        tick(2);
        chk("R2 hold before third clock", prevHi, prevLo);
        tick(1);
        chk("R2 R4 hall step", VEC[idx][5:3], VEC[idx][2:0]);
        sweepCfg(VEC[idx][5:3], VEC[idx][2:0], "R6 R7 R8 R9 hall sweep");
        prevHi = VEC[idx][5:3]; prevLo = VEC[idx][2:0];
      end
    end

    // R3 R5: software mode, all eight codes
    swPhase = 3'b000; fbSel = 1'b1;
    tick(1);
    chk("R10 switch to software idle", 3'b000, 3'b000);
    for (int e = 0; e < 8; e++) begin
      swPhase = VEC[e][8:6];
      tick(1);
      chk("R3 R4 R5 software step", VEC[e][5:3], VEC[e][2:0]);
      sweepCfg(VEC[e][5:3], VEC[e][2:0], "R5 R6 R7 R8 software sweep");
    end

    // R11: hall changes ignored in software mode
    swPhase = 3'b101;
    tick(1);
    hallIn = 3'b010;
    tick(4);
    chk("R11 hall ignored", 3'b001, 3'b010);
    hallIn = 3'b011;
    tick(4);
    chk("R11 hall ignored again", 3'b001, 3'b010);

    // R10: source switch while running
    fbSel = 1'b0;
    tick(1);
    chk("R10 switch to hall", 3'b100, 3'b001);
    swPhase = 3'b110;
    tick(2);
    chk("R10 software ignored in hall mode", 3'b100, 3'b001);
    fbSel = 1'b1;
    tick(1);
    chk("R10 switch back to software", 3'b010, 3'b100);

    // R5 R8: invalid code with inverted polarity and chopping on
    swPhase = 3'b111; actLvlHi = 0; actLvlLo = 1; chopEnHi = 1; pwmHi = 1;
    tick(1);
    chk("R5 R8 invalid code idle", 3'b111, 3'b000);

    // R3: latency of a software change is a single clock
    steadyCfg();
    swPhase = 3'b011;
    @(posedge clk); #1;
    chk("R3 one clock", 3'b100, 3'b001);

    tick(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule